// File: doc/BRIEF.md
# Sync-Framed Nibble Word Receiver

This block rebuilds 12-bit two's-complement samples from a 6-bit nibble bus that runs at twice the word rate. A sync strobe, sampled together with each nibble on the rising clock edge, says which half of a word the nibble belongs to. A low sync level marks the upper half. A high sync level on the cycle right after it marks the lower half. Each rebuilt word leaves the block with a one-cycle valid pulse.

If the sender holds sync low for several cycles, the upper-half register is loaded again on each of those cycles and no word comes out. The host can use this to park the stream, for example while it flushes a downstream filter with zero words, and then start again cleanly. A sync-high cycle that does not directly follow a sync-low cycle does not frame anything, so it is dropped.

The output is a valid-only stream and has no ready input. Back-pressure is not possible, because the nibble source cannot be stalled. The consumer must take every word in the cycle in which the valid strobe is high. Between pulses the word output keeps its last value.

Top module: `nibble_word_rx`

## Requirements
- R1: A nibble sampled while sync is low (0) is stored as the upper half of the next word, which is bits [11:6] of the word output.
- R2: A nibble sampled with sync high (1), on the cycle directly after a sync-low cycle, completes the word as {stored upper nibble, this nibble}. This nibble is bits [5:0].
- R3: The valid strobe is high for exactly one cycle, starting right after the clock edge that samples the lower nibble. With sync alternating low and high, one word completes every two cycles.
- R4: During a run of consecutive sync-low cycles, the upper nibble is reloaded on every cycle and no valid strobe appears. The next word uses the nibble from the last low cycle of the run.
- R5: A sync-high cycle whose preceding cycle was not sync-low produces no valid strobe and leaves the word output unchanged.
- R6: The word output keeps its value in every cycle without a valid strobe.
- R7: Active-low reset clears the word output to 0, clears the valid strobe and clears the framing state. A sync-high cycle directly after reset produces no word.
- R8: Zero nibbles framed normally produce a valid word of value 0, so flush words pass through like any other data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock. Inputs are sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_i | input | 6 | Nibble bus |
| sync_i | input | 1 | Framing strobe: 0 = upper nibble, 1 = lower nibble |
| word_o | output | 12 | Last rebuilt word |
| word_valid_o | output | 1 | One-cycle pulse for each new word. There is no ready. |

## Verification
A word is due in the same cycle that follows the edge that samples its lower nibble. Because of this, the bench drives each nibble and sync pair on the falling edge and lets one rising edge pass. On the next falling edge it compares both outputs with a bench model, before it drives anything new. Every cycle is checked this way, not only the cycles with a valid strobe. As a result, the missing pulses during sync-low runs and after isolated sync-high cycles are confirmed in the cycle where a pulse would otherwise have been, and the unchanged word value is confirmed in the same check.

// File: rtl/nibrx_pkg.sv
package nibrx_pkg;
  // Framing state: whether an upper nibble is waiting for its lower half
  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_ARMED = 1'b1
  } frame_t;
endpackage

// File: rtl/nibrx_framer.sv
module nibrx_framer
  import nibrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic load_hi_o,
  output logic commit_o
);
  frame_t state_q;

  // A low sync level always (re)loads the upper half
  assign load_hi_o = ~sync_i;
  // A high sync level closes a word only if the previous cycle was low
  assign commit_o  = sync_i & (state_q == FR_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
    end else begin
      state_q <= sync_i ? FR_IDLE : FR_ARMED;
    end
  end
endmodule

// File: rtl/nibrx_packer.sv
module nibrx_packer #(
  parameter int unsigned NIB_W = 6,
  localparam int unsigned WORD_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              load_hi_i,
  input  logic              commit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [NIB_W-1:0]  upper_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
    end else if (load_hi_i) begin
      upper_q <= nib_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= commit_i;
      if (commit_i) begin
        word_q <= {upper_q, nib_i};
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/nibble_word_rx.sv
module nibble_word_rx #(
  parameter int unsigned NIB_W = 6,
  localparam int unsigned WORD_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              sync_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic load_hi;
  logic commit;

  nibrx_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .load_hi_o (load_hi),
    .commit_o  (commit)
  );

  nibrx_packer #(.NIB_W(NIB_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .nib_i     (nib_i),
    .load_hi_i (load_hi),
    .commit_i  (commit),
    .word_o    (word_o),
    .valid_o   (word_valid_o)
  );
endmodule

// File: rtl/nibble_word_rx_chk.sv
module nibble_word_rx_chk #(
  parameter int unsigned NIB_W = 6,
  localparam int unsigned WORD_W = 2 * NIB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NIB_W-1:0]  nib_i,
  input logic              sync_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o
);
  // R3: a word pulse never lasts beyond one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R4: a sync-low sample never produces a word
  assert_low_no_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_i) |-> !word_valid_o);

  // R2: lower half equals the nibble sampled with sync high
  assert_lower_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_o[NIB_W-1:0] == $past(nib_i)));

  // R1: upper half equals the nibble sampled one cycle earlier with sync low
  assert_upper_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_o[WORD_W-1:NIB_W] == $past(nib_i, 2)) && !$past(sync_i, 2));

  // R6: without a pulse the word output keeps its value
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));
endmodule

bind nibble_word_rx nibble_word_rx_chk #(.NIB_W(NIB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .nib_i        (nib_i),
  .sync_i       (sync_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/sim_nibble_word_rx.sv
`timescale 1ns/1ps
module sim_nibble_word_rx;
  localparam int NW = 6;
  localparam int WW = 2 * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] nib = '0;
  logic          sync = 1'b0;
  logic [WW-1:0] word;
  logic          wvalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state, built from the requirements
  bit            m_armed = 1'b0;
  logic [NW-1:0] m_upper = '0;
  logic [WW-1:0] m_word = '0;
  bit            m_valid = 1'b0;

  always #10 clk = ~clk;

  nibble_word_rx #(.NIB_W(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .nib_i(nib), .sync_i(sync),
    .word_o(word), .word_valid_o(wvalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [WW-1:0] pack(input logic [NW-1:0] hi, input logic [NW-1:0] lo);
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act_w, input logic act_v,
                     input logic [WW-1:0] exp_w, input logic exp_v);
    checks = checks + 1;
    if (act_w !== exp_w || act_v !== exp_v) begin
      errors = errors + 1;
      $display("FAIL %s: actual word=%h valid=%b expected word=%h valid=%b",
               tag, act_w, act_v, exp_w, exp_v);
    end
  endtask

  // drive one cycle, advance the model, compare at the next falling edge
  task automatic step(input logic [NW-1:0] n, input logic s, input string tag);
    bit prev_armed;
    nib = n;
    sync = s;
    @(posedge clk);
    prev_armed = m_armed;
    m_valid = s && prev_armed;
    if (m_valid) m_word = pack(m_upper, n);
    if (!s) m_upper = n;
    m_armed = !s;
    @(negedge clk);
    chk(tag, word, wvalid, m_word, m_valid);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    checks = checks + 1;
    if (word !== '0 || wvalid !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R7 reset: actual word=%h valid=%b expected word=000 valid=0", word, wvalid);
    end
    rst_n = 1'b1;
    // R7: sync high straight after reset frames nothing
    step(6'h2A, 1'b1, "R7 sync-high after reset");
    // R1 R2 R3: steady alternation
    step(6'h15, 1'b0, "R1 upper capture");
    step(6'h2C, 1'b1, "R2 lower completes word");
    step(6'h3F, 1'b0, "R3 alternation low");
    step(6'h01, 1'b1, "R3 alternation word");
    // R4: long low run, last upper wins
    step(6'h11, 1'b0, "R4 low run");
    step(6'h22, 1'b0, "R4 low run");
    step(6'h33, 1'b0, "R4 low run");
    step(6'h07, 1'b1, "R4 word after run");
    // R5 R6: isolated high cycles
    step(6'h3C, 1'b1, "R5 isolated high");
    step(6'h03, 1'b1, "R5 isolated high");
    step(6'h1E, 1'b1, "R6 hold");
    // R8: zero flush words
    for (int i = 0; i < 4; i++) begin
      step(6'h00, 1'b0, "R8 flush low");
      step(6'h00, 1'b0, "R8 flush low");
      step(6'h00, 1'b1, "R8 zero word");
    end
    // mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic s;
      logic [NW-1:0] n;
      n = NW'($urandom);
      s = ($urandom % 3) != 0 ? !sync : sync;
      step(n, s, s ? (m_armed ? "R2 random word" : "R5 random isolated high")
                   : "R4 random low");
    end
    // R7: mid-stream reset, then orphan high
    step(6'h2B, 1'b0, "R1 pre-reset upper");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks = checks + 1;
    if (word !== '0 || wvalid !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R7 mid reset: actual word=%h valid=%b expected word=000 valid=0", word, wvalid);
    end
    m_armed = 1'b0; m_upper = '0; m_word = '0; m_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(6'h19, 1'b1, "R7 framing cleared");
    step(6'h0A, 1'b0, "R1 upper after reset");
    step(6'h35, 1'b1, "R2 word after reset");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule